// File: doc/BRIEF.md
# Serial-Load Latched Switch Control Register

This block is the digital control core of a bank of switch drivers. Control bits arrive one per clock on a serial input and move through a shift register. The register is built from one or more 16-stage slices, each slice standing for one cascaded device. A holding stage sits between each register stage and its switch-enable output. An active-low load strobe either lets the register show straight through or freezes the last value captured. An active-high clear turns every enable off without disturbing the register. The last stage of the chain is brought out so that further devices can be chained behind it.

Software or a controller upstream shifts in a whole frame of `CHAN*NDEV` bits while the strobe is high, so the enables do not ripple during the load. It then pulses the strobe low to make the new frame visible, and raises it again to freeze that frame. Outputs are plain logic enables, where 1 means the switch is on.

The strobe and the clear act on the outputs combinationally. The holding stage is updated on the clock edge. Its value is always the register content present at the moment the strobe rises.

Top module: `sw_ctrl_chain`

## Requirements
- R1: On each rising edge of `clk`, `ser_in` enters stage 0 of slice 0, and every stage takes the value of the stage below it, across the full chain of `CHAN*NDEV` stages.
- R2: Stage n of slice k drives `sw_en[k*CHAN+n]`, where 1 means on. After a frame of `CHAN*NDEV` bits, the first bit shifted controls the highest index, `sw_en[CHAN*NDEV-1]`.
- R3: While `le_n` is 0 and `clr` is 0, `sw_en` equals the register contents. It follows a fall of `le_n` in the same cycle, before any clock edge.
- R4: When `le_n` rises, `sw_en` keeps the register contents present at that moment for as long as `le_n` stays 1.
- R5: While `le_n` is 1, shifting the register does not change `sw_en`.
- R6: While `clr` is 1, `sw_en` is all zeros at once, whatever the other inputs are.
- R7: `ser_out` equals the last stage of the last slice. The stage 0 of slice k>0 loads from the last stage of slice k-1.
- R8: `clr` does not alter or stop the shift register. Releasing `clr` while `le_n` is 0 shows the register contents again.
- R9: A clock edge with `clr` at 1 empties the held value. Releasing `clr` while `le_n` is 1 then leaves `sw_en` all zeros until `le_n` falls.
- R10: `rst_n` at 0 clears the register and the held value asynchronously, so `sw_en` and `ser_out` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 of slice 0 |
| le_n | input | 1 | Active-low load strobe: 0 shows the register, 1 holds |
| clr | input | 1 | Active-high clear of all enables |
| sw_en | output | CHAN*NDEV | Switch enables, 1 = on |
| ser_out | output | 1 | Last chain stage, feeds the next device |

## Verification
A fixed 32-bit frame is loaded with the strobe held high. This separates correct bit ordering and slice-to-slice chaining from a reversed or broken chain, and shows that the outputs stay frozen while loading. The strobe is then pulsed around further shifting, to tell a captured value apart from a live one. Clear is applied once with the strobe low and once with it high. The first case shows that the register survives a clear. The second shows that the held value is emptied. A long random mix of data, strobe and clear, checked against a reference model each half cycle, exposes errors in priority and timing that the directed cases do not reach.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  localparam int unsigned SC_CHAN_DEFAULT = 16;

  // Output gating for one enable: clear wins, else strobe low shows live bit.
  function automatic logic sc_gate_bit(input logic clr, input logic le_n,
                                       input logic live, input logic held);
    if (clr) return 1'b0;
    return le_n ? held : live;
  endfunction
endpackage

// File: rtl/sc_slice.sv
module sc_slice #(
  parameter int unsigned CHAN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic            le_n,
  input  logic            clr,
  output logic [CHAN-1:0] live_q,
  output logic [CHAN-1:0] held_q,
  output logic            dout
);
  function automatic logic [CHAN-1:0] push_bit(input logic [CHAN-1:0] v,
                                               input logic b);
    return {v[CHAN-2:0], b};
  endfunction

  logic [CHAN-1:0] live_nxt;
  logic            capture_en;

  assign live_nxt   = push_bit(live_q, din);
  assign capture_en = !le_n && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held_q <= '0;
    else if (clr)        held_q <= '0;
    else if (capture_en) held_q <= live_nxt;
  end

  assign dout = live_q[CHAN-1];
endmodule

// File: rtl/sc_gate.sv
module sc_gate #(
  parameter int unsigned W = 16
) (
  input  logic         le_n,
  input  logic         clr,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] en
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign en[i] = sw_ctrl_pkg::sc_gate_bit(clr, le_n, live[i], held[i]);
  end
endmodule

// File: rtl/sw_ctrl_chain.sv
module sw_ctrl_chain #(
  parameter int unsigned CHAN = sw_ctrl_pkg::SC_CHAN_DEFAULT,
  parameter int unsigned NDEV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 le_n,
  input  logic                 clr,
  output logic [CHAN*NDEV-1:0] sw_en,
  output logic                 ser_out
);
  localparam int unsigned TOTAL = CHAN * NDEV;

  logic [NDEV:0]    link;
  logic [TOTAL-1:0] chain_q;
  logic [TOTAL-1:0] held_all;

  assign link[0] = ser_in;

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    sc_slice #(.CHAN(CHAN)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (link[k]),
      .le_n   (le_n),
      .clr    (clr),
      .live_q (chain_q[k*CHAN +: CHAN]),
      .held_q (held_all[k*CHAN +: CHAN]),
      .dout   (link[k+1])
    );
  end

  sc_gate #(.W(TOTAL)) u_gate (
    .le_n (le_n),
    .clr  (clr),
    .live (chain_q),
    .held (held_all),
    .en   (sw_en)
  );

  assign ser_out = link[NDEV];
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
  parameter int unsigned CHAN = 16,
  parameter int unsigned NDEV = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ser_in,
  input logic                 le_n,
  input logic                 clr,
  input logic [CHAN*NDEV-1:0] sw_en,
  input logic                 ser_out,
  input logic [CHAN*NDEV-1:0] chain
);
  localparam int unsigned W = CHAN * NDEV;

  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chain[W-1:1] == $past(chain[W-2:0])) && (chain[0] == $past(ser_in)));

  a_r3_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && !clr) |-> (sw_en == chain));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(le_n) && !clr && !$past(clr)) |-> (sw_en == chain));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((le_n && !clr) ##1 (le_n && !clr)) |-> $stable(sw_en));

  a_r6_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (sw_en == '0));

  a_r7_chain_tail: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ser_out == $past(chain[W-2])));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr ##1 (le_n && !clr)) |-> (sw_en == '0));
endmodule

bind sw_ctrl_chain sc_checker #(.CHAN(CHAN), .NDEV(NDEV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ser_in  (ser_in),
  .le_n    (le_n),
  .clr     (clr),
  .sw_en   (sw_en),
  .ser_out (ser_out),
  .chain   (chain_q)
);

// File: tb/tb_sw_ctrl_chain.sv
`timescale 1ns/1ps
module tb_sw_ctrl_chain;
  localparam int unsigned CHAN = 16;
  localparam int unsigned NDEV = 2;
  localparam int unsigned W    = CHAN * NDEV;

  logic         clk = 1'b0;
  logic         rst_n, ser_in, le_n, clr;
  logic [W-1:0] sw_en;
  logic         ser_out;

  logic [W-1:0] m_reg, m_hold;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sw_ctrl_chain #(.CHAN(CHAN), .NDEV(NDEV)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .le_n(le_n), .clr(clr),
    .sw_en(sw_en), .ser_out(ser_out));

  function automatic logic [W-1:0] want_en();
    if (clr) return '0;
    if (!le_n) return m_reg;
    return m_hold;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " sw_en"}, sw_en, want_en());
    chk({tag, " ser_out R7"}, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_reg[W-1]});
  endtask

  // One clock: drive at falling edge, check before and after the rising edge.
  task automatic cyc(input logic d, input logic le, input logic c, input string tag);
    @(negedge clk);
    ser_in = d; le_n = le; clr = c;
    #1 chk_all({tag, " pre"});
    @(posedge clk);
    m_reg = {m_reg[W-2:0], d};
    if (c) m_hold = '0;
    else if (!le) m_hold = m_reg;
    #1 chk_all({tag, " post"});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [W-1:0] frame;
    logic [W-1:0] snap;
    void'($urandom(32'd1357));
    rst_n = 0; ser_in = 0; le_n = 1; clr = 0;
    m_reg = '0; m_hold = '0;
    repeat (3) @(posedge clk);
    #1 chk("R10 reset sw_en", sw_en, '0);
    chk("R10 reset ser_out", {{(W-1){1'b0}}, ser_out}, '0);
    @(negedge clk); rst_n = 1;

    // R1 R2 R5: load a frame with strobe high, outputs frozen at zero
    frame = 32'hA5C3_0F96;
    for (int i = W - 1; i >= 0; i--) cyc(frame[i], 1'b1, 1'b0, "R5 load");
    chk("R5 frozen during load", sw_en, '0);
    chk("R7 tail is first bit", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, frame[W-1]});

    // R3 R2: strobe low shows the frame at once, first bit at top index
    @(negedge clk); le_n = 0; ser_in = 1'b0; #1;
    chk("R2 R3 transparent frame", sw_en, frame);
    @(posedge clk); m_reg = {m_reg[W-2:0], 1'b0}; m_hold = m_reg;
    #1 chk("R1 shift while transparent", sw_en, {frame[W-2:0], 1'b0});

    // R4: raise strobe, shift more, held value stays
    snap = m_reg;
    for (int i = 0; i < 16; i++) cyc(i[0], 1'b1, 1'b0, "R4 hold");
    chk("R4 captured value kept", sw_en, snap);

    // R6 R8: clear with strobe low, register untouched
    cyc(1'b1, 1'b0, 1'b1, "R6 clear low");
    chk("R6 clear forces off", sw_en, '0);
    cyc(1'b0, 1'b0, 1'b0, "R8 release");
    chk("R8 register restored", sw_en, m_reg);

    // R9: clear pulse with strobe high empties held value
    cyc(1'b1, 1'b1, 1'b0, "R9 setup");
    cyc(1'b1, 1'b1, 1'b1, "R9 pulse");
    cyc(1'b0, 1'b1, 1'b0, "R9 after");
    chk("R9 held emptied", sw_en, '0);
    @(negedge clk); le_n = 0; #1;
    chk("R9 strobe low shows register", sw_en, m_reg);
    @(posedge clk); m_reg = {m_reg[W-2:0], ser_in}; m_hold = m_reg;
    #1;

    // Random mix (R1 R3 R4 R5 R6 R8 R9)
    for (int i = 0; i < 400; i++) begin
      logic d, le, c;
      d  = 1'($urandom);
      le = ($urandom % 10) < 7;
      c  = ($urandom % 10) == 0;
      cyc(d, le, c, "rand R3 R4 R6");
    end

    finish_up();
  end
endmodule